// File: doc/BRIEF.md
# Delayed-Transaction Target Lock Tracker

This block is the target-side controller for one delayed transaction on a PCI-style bus. A decoded request is never finished on its first attempt. The controller answers it with retry and latches its address, command, byte enables and sampled lock flag. It then issues the request to a back-end completion port. Each later attempt is answered with retry until the back end reports done. After that, an attempt that matches the latched request receives the held read data and a one-cycle complete.

Exclusive access is tracked from the moment a locked request is taken in, before any data moves. While the target is locked, no other request is enqueued. After a locked completion, the target stays locked and accepts only locked requests until the lock owner releases it. By default a repeat is recognised only if its lock flag also matches. A relaxed-match input drops the lock flag from that comparison, because a strict match can stall an initiator for ever when it repeats a locked request without the flag. Foreign requests are still refused in relaxed mode. A completion that is never claimed is discarded after a fixed number of cycles, and any lock it held is released.

Top module: `dtx_lock_target`

## Requirements
- R1: In the idle state, a request is answered with retry and its fields are latched. One cycle later, `be_launch_o` pulses for one cycle and `be_addr_o`, `be_cmd_o` and `be_be_o` carry the latched fields.
- R2: While the back end is busy, every attempt is answered with retry. `be_done_i` moves the controller to the completion-held state.
- R3: In the completion-held state, a matching attempt gets `complete_o` high, `retry_o` low and `rdata_o` equal to the `be_rdata_i` value captured with done. A non-matching attempt gets retry.
- R4: An attempt matches only if address, command, byte enables and, in strict mode (`relax_lock_i`=0), the lock flag all equal the latched values.
- R5: A request with `req_lock_i`=1 taken in from idle sets `locked_o` on the next cycle, while the back end is still busy.
- R6: While `locked_o` is 1, a request without the lock flag is refused with retry and is never enqueued (no `be_launch_o` follows it).
- R7: With `relax_lock_i`=1, a repeat that differs only in the lock flag completes, while a request with other fields still gets retry.
- R8: After a locked completion, `locked_o` stays 1. A locked request is then enqueued as a new delayed request. `lock_release_i`=1 with no request present returns the controller to idle with `locked_o`=0.
- R9: A held completion that is not claimed within 2^DISCARD_W cycles in the completion-held state is dropped. The controller returns to idle with `locked_o`=0, and a later repeat is retried rather than completed.
- R10: During and after reset, `retry_o`, `complete_o`, `be_launch_o` and `locked_o` are 0 when no request is present.
- R11: Every request cycle is answered with exactly one of `retry_o` and `complete_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Decoded request strobe, one cycle per attempt |
| req_addr_i | input | ADDR_W | Request address |
| req_cmd_i | input | CMD_W | Request command code |
| req_be_i | input | BE_W | Request byte enables |
| req_lock_i | input | 1 | Sampled lock flag of the attempt |
| relax_lock_i | input | 1 | 1 = lock flag left out of the repeat match |
| lock_release_i | input | 1 | Lock owner deasserted lock with no request |
| be_launch_o | output | 1 | One-cycle pulse issuing the latched request |
| be_addr_o | output | ADDR_W | Latched address |
| be_cmd_o | output | CMD_W | Latched command |
| be_be_o | output | BE_W | Latched byte enables |
| be_done_i | input | 1 | Back end finished the request |
| be_rdata_i | input | DATA_W | Back-end read data, valid with done |
| retry_o | output | 1 | Attempt answered with retry |
| complete_o | output | 1 | Attempt completed this cycle |
| rdata_o | output | DATA_W | Held read data, valid with complete |
| locked_o | output | 1 | Target is exclusively locked |

## Verification
The bench repeats a locked request without its lock flag. In strict mode that repeat must get retry, and in relaxed mode it must complete. A design that ignores the mode would either deadlock or complete a non-exclusive repeat. The bench sends foreign requests while a locked request is pending and again after the lock is established. It checks that no back-end launch follows them, which catches a design that locks only after data or that overwrites the latched slot. It lets a locked completion go stale past the discard window and checks `locked_o` just before and well after expiry. This exposes a timer that is off by a large margin or a discard that leaves the lock set. It also checks that a byte-enable difference alone defeats the match.

// File: rtl/dtx_pkg.sv
// Shared types for the delayed-transaction lock tracker.
// Assumes: a single delayed-request slot.
package dtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PENDING     = 2'd1,
        ST_READY       = 2'd2,
        ST_LOCKED_IDLE = 2'd3
    } dtx_state_e;
endpackage

// File: rtl/dtx_req_hold.sv
// Latches the fields of the request that was retried first, and compares
// each later attempt against them.
// Assumes: capture_i is high only on the cycle a request is enqueued.
module dtx_req_hold #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              lock_i,
    input  logic              relax_i,
    output logic [ADDR_W-1:0] hold_addr_o,
    output logic [CMD_W-1:0]  hold_cmd_o,
    output logic [BE_W-1:0]   hold_be_o,
    output logic              hold_lock_o,
    output logic              match_o
);
    // Latch the request fields when the controller enqueues a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr_o <= '0;
            hold_cmd_o  <= '0;
            hold_be_o   <= '0;
            hold_lock_o <= 1'b0;
        end else if (capture_i) begin
            hold_addr_o <= addr_i;
            hold_cmd_o  <= cmd_i;
            hold_be_o   <= be_i;
            hold_lock_o <= lock_i;
        end
    end

    // Field compare; in relaxed mode the lock flag is left out.
    always_comb begin
        match_o = (addr_i == hold_addr_o) && (cmd_i == hold_cmd_o) &&
                  (be_i == hold_be_o) && (relax_i || (lock_i == hold_lock_o));
    end
endmodule

// File: rtl/dtx_discard_timer.sv
// Counts cycles while a completion is held and flags the last cycle of
// the 2^CNT_W window.
// Assumes: run_i drops for at least one cycle between two held completions.
module dtx_discard_timer #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count while running; restart from zero whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag on the final cycle of the window.
    always_comb expire_o = run_i && (&cnt_q);
endmodule

// File: rtl/dtx_lock_target.sv
// Target-side controller for one delayed transaction with exclusive
// access tracking. It retries the first attempt, launches it to the back
// end, holds the completion and hands it to a matching repeat. A locked
// request locks the target as soon as it is enqueued.
// Assumes: req_valid_i is a one-cycle decoded strobe per bus attempt;
// be_done_i is asserted only while a request is outstanding.
module dtx_lock_target
    import dtx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CMD_W     = 4,
    parameter int BE_W      = 4,
    parameter int DATA_W    = 32,
    parameter int DISCARD_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [CMD_W-1:0]  req_cmd_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic              req_lock_i,
    input  logic              relax_lock_i,
    input  logic              lock_release_i,
    output logic              be_launch_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic [CMD_W-1:0]  be_cmd_o,
    output logic [BE_W-1:0]   be_be_o,
    input  logic              be_done_i,
    input  logic [DATA_W-1:0] be_rdata_i,
    output logic              retry_o,
    output logic              complete_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              locked_o
);
    dtx_state_e        state_q, state_d;
    logic              locked_q, locked_d;
    logic              capture;
    logic              launch_q;
    logic [DATA_W-1:0] rdata_q;
    logic              match;
    logic              hold_lock;
    logic              expire;

    dtx_req_hold #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .addr_i     (req_addr_i),
        .cmd_i      (req_cmd_i),
        .be_i       (req_be_i),
        .lock_i     (req_lock_i),
        .relax_i    (relax_lock_i),
        .hold_addr_o(be_addr_o),
        .hold_cmd_o (be_cmd_o),
        .hold_be_o  (be_be_o),
        .hold_lock_o(hold_lock),
        .match_o    (match)
    );

    dtx_discard_timer #(.CNT_W(DISCARD_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_READY),
        .expire_o(expire)
    );

    // Next state, lock state and the answer to the current attempt.
    always_comb begin
        state_d  = state_q;
        locked_d = locked_q;
        capture  = 1'b0;
        retry_o  = 1'b0;
        complete_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    retry_o  = 1'b1;
                    capture  = 1'b1;
                    locked_d = req_lock_i;
                    state_d  = ST_PENDING;
                end
            end
            ST_PENDING: begin
                retry_o = req_valid_i;
                if (be_done_i) state_d = ST_READY;
            end
            ST_READY: begin
                if (req_valid_i && match) begin
                    complete_o = 1'b1;
                    state_d    = hold_lock ? ST_LOCKED_IDLE : ST_IDLE;
                end else begin
                    retry_o = req_valid_i;
                    if (expire) begin
                        state_d  = ST_IDLE;
                        locked_d = 1'b0;
                    end
                end
            end
            ST_LOCKED_IDLE: begin
                if (req_valid_i) begin
                    retry_o = 1'b1;
                    if (req_lock_i) begin
                        capture = 1'b1;
                        state_d = ST_PENDING;
                    end
                end else if (lock_release_i) begin
                    state_d  = ST_IDLE;
                    locked_d = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, lock and launch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            locked_q <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            locked_q <= locked_d;
            launch_q <= capture;
        end
    end

    // Hold back-end read data when the completion arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rdata_q <= '0;
        else if (state_q == ST_PENDING && be_done_i)  rdata_q <= be_rdata_i;
    end

    assign be_launch_o = launch_q;
    assign locked_o    = locked_q;
    assign rdata_o     = complete_o ? rdata_q : '0;

    AST_LAUNCH_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        be_launch_o |-> $past(retry_o)); // R1
    AST_COMPLETE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |=> !complete_o); // R3
    AST_LOCK_ON_ENQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid_i && req_lock_i) |=> (locked_o && state_q == ST_PENDING)); // R5
    AST_NO_FOREIGN_ENQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && req_valid_i && !req_lock_i) |=> !be_launch_o); // R6
    AST_DISCARD_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(req_valid_i && match)) |=> (state_q == ST_IDLE && !locked_o)); // R9
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |-> $countones({retry_o, complete_o}) == 1); // R11
    AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> !(retry_o || complete_o)); // R11
endmodule

// File: tb/dtx_lock_target_bench.sv
module dtx_lock_target_bench;
    localparam logic [3:0]  CMD = 4'h6;
    localparam logic [7:0]  A   = 8'h10;
    localparam logic [7:0]  B   = 8'h20;
    localparam logic [31:0] RD  = 32'hA5A5_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_lock = 0, relax = 0, release_l = 0, done = 0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic        launch, retry, cpl, locked;
    logic [31:0] be_addr, rdata;
    logic [3:0]  be_cmd, be_be;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dtx_lock_target u_dtx_lock_target (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_cmd_i(CMD), .req_be_i(req_be), .req_lock_i(req_lock),
        .relax_lock_i(relax), .lock_release_i(release_l), .be_launch_o(launch),
        .be_addr_o(be_addr), .be_cmd_o(be_cmd), .be_be_o(be_be), .be_done_i(done),
        .be_rdata_i(RD), .retry_o(retry), .complete_o(cpl), .rdata_o(rdata),
        .locked_o(locked)
    );

    // {valid, lock, done, relax, release, be_alt, addr[7:0], exp retry, exp complete, exp locked, exp launch}
    function automatic logic [17:0] row(input bit v, lk, dn, rx, rl, ba,
                                        input logic [7:0] a, input bit r, c, l, la);
        return {v, lk, dn, rx, rl, ba, a, r, c, l, la};
    endfunction

    localparam int N = 20;
    localparam logic [17:0] TBL [0:N-1] = '{
        row(1,0,0,0,0,0,A, 1,0,0,0), // R1 first attempt retried
        row(1,0,0,0,0,0,A, 1,0,0,1), // R2 busy retry, R1 launch
        row(0,0,1,0,0,0,0, 0,0,0,0), // R2 done
        row(1,0,0,0,0,0,B, 1,0,0,0), // R3 R4 address mismatch
        row(1,0,0,0,0,1,A, 1,0,0,0), // R4 byte-enable mismatch
        row(1,0,0,0,0,0,A, 0,1,0,0), // R3 complete
        row(1,1,0,0,0,0,A, 1,0,0,0), // R5 locked request enqueued
        row(0,0,0,0,0,0,0, 0,0,1,1), // R5 locked before data
        row(1,0,0,0,0,0,B, 1,0,1,0), // R6 foreign refused while pending
        row(0,0,1,0,0,0,0, 0,0,1,0), // R6 no launch, done
        row(1,0,0,0,0,0,A, 1,0,1,0), // R4 strict lock mismatch
        row(1,0,0,1,0,0,B, 1,0,1,0), // R7 relaxed still refuses foreign
        row(1,0,0,1,0,0,A, 0,1,1,0), // R7 relaxed completes
        row(1,0,0,0,0,0,B, 1,0,1,0), // R6 R8 non-lock refused in locked idle
        row(0,0,0,0,0,0,0, 0,0,1,0), // R6 no launch
        row(1,1,0,0,0,0,B, 1,0,1,0), // R8 owner request enqueued
        row(0,0,1,0,0,0,0, 0,0,1,1), // R8 launch, done
        row(1,1,0,0,0,0,B, 0,1,1,0), // R8 owner completes
        row(0,0,0,0,1,0,0, 0,0,1,0), // R8 release
        row(0,0,0,0,0,0,0, 0,0,0,0)  // R8 unlocked
    };

    task automatic check(input bit ok, input string what, input logic [31:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input bit v, lk, dn, rx, rl, ba, input logic [7:0] a);
        @(negedge clk);
        req_valid = v; req_lock = lk; done = dn; relax = rx; release_l = rl;
        req_be = ba ? 4'h3 : 4'hF; req_addr = {24'h0, a};
        #5;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] last_addr;
        last_addr = '0;
        repeat (3) @(negedge clk);
        #5;
        check(!retry && !cpl && !launch && !locked, "R10 outputs in reset", {retry, cpl, launch, locked}, 0);
        @(negedge clk) rst_n = 1'b1;
        #5;
        check(!retry && !cpl && !launch && !locked, "R10 outputs after reset", {retry, cpl, launch, locked}, 0);

        for (int i = 0; i < N; i++) begin
            logic [17:0] t;
            t = TBL[i];
            drive(t[17], t[16], t[15], t[14], t[13], t[12], t[11:4]);
            check(retry == t[3], $sformatf("R3 R11 retry row %0d", i), retry, t[3]);
            check(cpl == t[2], $sformatf("R3 R11 complete row %0d", i), cpl, t[2]);
            check(locked == t[1], $sformatf("R5 R8 locked row %0d", i), locked, t[1]);
            check(launch == t[0], $sformatf("R1 launch row %0d", i), launch, t[0]);
            if (t[0])
                check(be_addr == {24'h0, last_addr} && be_cmd == CMD && be_be == 4'hF,
                      $sformatf("R1 launched fields row %0d", i), be_addr, {24'h0, last_addr});
            if (t[2])
                check(rdata == RD, $sformatf("R3 read data row %0d", i), rdata, RD);
            if (t[17]) last_addr = t[11:4];
        end

        // R9: locked completion left unclaimed is discarded with its lock.
        drive(1, 1, 0, 0, 0, 0, A);
        drive(0, 0, 1, 0, 0, 0, 0);
        repeat (32000) drive(0, 0, 0, 0, 0, 0, 0);
        check(locked == 1'b1, "R9 lock held before discard", locked, 1);
        repeat (800) drive(0, 0, 0, 0, 0, 0, 0);
        check(locked == 1'b0, "R9 lock dropped after discard", locked, 0);
        drive(1, 1, 0, 0, 0, 0, A);
        check(retry && !cpl, "R9 stale repeat retried", {retry, cpl}, 2'b10);
        drive(0, 0, 0, 0, 0, 0, 0);
        check(locked == 1'b1, "R5 re-enqueued lock", locked, 1);

        // R10: reset in the middle of a locked request.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        #5;
        check(!locked && !launch && !retry, "R10 reset clears lock", {locked, launch, retry}, 0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule